// File: doc/BRIEF.md
# Microsecond Timestamp Counter with Fractional Tick Divider

This block keeps a free-running up-counter that software reads as a timestamp. The counter is clocked by a peripheral oscillator, and a fractional divider turns that oscillator into a steady microsecond tick. On each oscillator cycle the divider adds a programmable numerator to an accumulator. When the accumulator reaches a programmable denominator, the denominator is taken away and one tick is issued. Each tick advances the counter by one.

The block comes out of reset already counting at the rate for a 12 MHz oscillator, so no software setup is needed. The counter wraps silently and raises no interrupt. A control bit can stop both the counter and the divider so that software can take a stable reading.

Access is through a simple synchronous bus. A write happens on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `usec_counter`

## Requirements
- R1: After reset the timestamp reads 0, the rate register at byte offset 0x04 reads 0x0000000B, and the hold register at byte offset 0x3C reads 0.
- R2: With the reset rate, the timestamp first reads 1 after the 12th clock edge following reset release, and it then advances by one every 12 edges.
- R3: The rate register keeps the numerator-minus-one in bits 15:8 and the denominator-minus-one in bits 7:0. Bits 31:16 read back as zero. For a numerator a and a denominator b with a ≤ b, over the N edges that follow a rate write the timestamp advances by floor(N·a/b).
- R4: When the numerator is greater than the denominator, the timestamp advances by one on every edge and never by more than one.
- R5: A write to the rate register clears the divider accumulator. The timestamp keeps its value, and it does not advance on the write edge.
- R6: While bit 0 of the hold register (offset 0x3C) is 1, neither the timestamp nor the accumulator changes. After the bit is cleared, counting carries on from the held fractional position. The bit reads back in bit 0, and the other bits read as zero.
- R7: The timestamp at offset 0x00 is read-only. A write to that offset changes no state.
- R8: Any offset other than 0x00, 0x04 and 0x3C reads as zero. Writes to such offsets change nothing.
- R9: The timestamp wraps from its all-ones value to zero, modulo 2^CNT_W, and the block has no interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the divider runs once per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |

## Verification
A wrong accumulator value has no direct effect on the outputs. It shows up only as a shifted tick phase: the timestamp moves one edge early or late, and this becomes visible within one denominator period of oscillator cycles. For that reason every rate check counts edges exactly from a rate write, which sets the accumulator to a known value. The checks after a hold also confirm that the fractional phase was kept across the hold. A wrong timestamp or a wrong hold bit can be read back on the next read. The wrap behaviour is checked on a narrow instance so that the rollover arrives within a few hundred cycles.

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W     = 32,
  parameter int FRAC_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CFG_RESET = 'h0000_000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int ACC_W = FRAC_W + 2;
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_RATE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_HOLD = ADDR_W'('h3C);
  localparam logic [2*FRAC_W-1:0] RATE_INIT = (2*FRAC_W)'(CFG_RESET);

  logic [FRAC_W-1:0] num_m1, den_m1;
  logic              hold;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;

  logic [ACC_W-1:0] step_amt, limit, sum, rem, acc_nx;
  logic             tick, rate_wr, hold_wr;
  logic             unused_wdata;

  assign step_amt = ACC_W'(num_m1) + ACC_W'(1);
  assign limit    = ACC_W'(den_m1) + ACC_W'(1);
  assign sum      = acc + step_amt;
  assign rem      = sum - limit;
  assign tick     = !hold && (sum >= limit);
  assign acc_nx   = tick ? ((rem < limit) ? rem : '0) : sum;

  assign rate_wr  = bus_wr && (bus_addr == OFF_RATE);
  assign hold_wr  = bus_wr && (bus_addr == OFF_HOLD);
  assign unused_wdata = ^bus_wdata[DATA_W-1:2*FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_m1 <= RATE_INIT[2*FRAC_W-1:FRAC_W];
      den_m1 <= RATE_INIT[FRAC_W-1:0];
      acc    <= '0;
      cnt    <= '0;
    end else if (rate_wr) begin
      num_m1 <= bus_wdata[2*FRAC_W-1:FRAC_W];
      den_m1 <= bus_wdata[FRAC_W-1:0];
      acc    <= '0;
    end else if (!hold) begin
      acc <= acc_nx;
      cnt <= cnt + CNT_W'(tick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold <= 1'b0;
    else if (hold_wr) hold <= bus_wdata[0];
  end

  always_comb begin
    case (bus_addr)
      OFF_CNT:  bus_rdata = DATA_W'(cnt);
      OFF_RATE: bus_rdata = DATA_W'({num_m1, den_m1});
      OFF_HOLD: bus_rdata = DATA_W'(hold);
      default:  bus_rdata = '0;
    endcase
  end

  // R4 R9: timestamp only ever steps by one (modulo width)
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

  // R6: hold freezes timestamp and accumulator
  a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !rate_wr) |=> (cnt == $past(cnt)) && (acc == $past(acc)));

  // R5: rate write restarts the accumulator, timestamp kept
  a_r5_rate_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (acc == '0) && (cnt == $past(cnt)));

  // R3: accumulator stays below the denominator
  a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc < limit);

  // R7: a write to the timestamp offset with hold set leaves it untouched
  a_r7_count_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CNT && hold) |=> cnt == $past(cnt));
endmodule

// File: tb/usec_counter_tb_top.sv
module usec_counter_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  localparam logic [31:0] V_RATE [NV] = '{32'h0000_000B, 32'h0000_0304, 32'h0000_0000,
    32'h0000_00FF, 32'h0000_0507, 32'h0000_0903, 32'h0000_FFFF, 32'h0000_0102};
  localparam int V_N   [NV] = '{120, 40, 50, 512, 20, 30, 33, 10};
  localparam int V_EXP [NV] = '{ 10, 32, 50,   2, 15, 30, 33,  6};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, rdata, w_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  usec_counter dut_i (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata(rdata));
  usec_counter #(.CNT_W(8)) wrap_i (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata(w_rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic steps(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, c0;
    @(negedge clk); @(negedge clk);
    rd(8'h00, d); check("R1 count", d, 0);
    rd(8'h04, d); check("R1 rate", d, 32'h0000_000B);
    rd(8'h3C, d); check("R1 hold", d, 0);
    rst_n = 1;
    steps(11); rd(8'h00, d); check("R2 before 12", d, 0);
    steps(1);  rd(8'h00, d); check("R2 at 12", d, 1);
    steps(12); rd(8'h00, d); check("R2 at 24", d, 2);

    for (int i = 0; i < NV; i++) begin
      wr(8'h04, V_RATE[i]);
      rd(8'h00, c0);
      steps(V_N[i]);
      rd(8'h00, d);
      check((V_RATE[i][15:8] > V_RATE[i][7:0]) ? "R4 fast rate" : "R3 fraction",
            d - c0, V_EXP[i]);
    end

    wr(8'h04, 32'hABCD_0B05); rd(8'h04, d); check("R3 rate readback", d, 32'h0000_0B05);

    // R5: rate write does not touch count, no tick on write edge
    wr(8'h04, 32'h0); rd(8'h00, c0);
    wr(8'h04, 32'h0); rd(8'h00, d); check("R5 count kept", d, c0);

    // R6: hold keeps fractional phase
    wr(8'h04, 32'h0000_000B);
    rd(8'h00, c0);
    steps(5);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, d); check("R6 hold readback", d, 1);
    rd(8'h00, d); check("R6 no tick yet", d, c0);
    steps(100); rd(8'h00, d); check("R6 held", d, c0);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R7 write ignored", d, c0);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); check("R8 unmapped 0x10", d, 0);
    rd(8'h08, d); check("R8 unmapped 0x08", d, 0);
    rd(8'h04, d); check("R8 rate untouched", d, 32'h0000_000B);
    wr(8'h3C, 32'h0);
    steps(5); rd(8'h00, d); check("R6 resume not yet", d, c0);
    steps(1); rd(8'h00, d); check("R6 resume tick", d, c0 + 1);

    // R9: wrap on the 8-bit instance
    wr(8'h04, 32'h0);
    bus_addr = 8'h00; #1; c0 = w_rdata;
    steps(256 - int'(c0)); bus_addr = 8'h00; #1;
    check("R9 wrap to zero", w_rdata, 0);
    steps(1); #1; check("R9 after wrap", w_rdata, 1);

    finish_run();
  end
endmodule